// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers eight level-sensitive interrupt request lines from peripherals and presents a single interrupt line to a processor. Each line passes through a two-flop synchronizer. It is then gated by its own enable bit, which is held in a mask register that a simple write port loads. Among the enabled requests that are active, the one with the lowest input index wins. Its index is captured as a binary IRQ number.

The controller keeps at most one interrupt outstanding. While an interrupt is pending, the captured number and the interrupt line stay frozen. Newly arriving requests do not change them, and neither does a mask change. A one-cycle acknowledge from the processor releases the pending state. Once released, the next winner can be captured one cycle later at the earliest.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_o` is 0, `irq_id_o` is 0 and every enable bit is 0, so no request can raise `irq_o` until the mask is written.
- R2: A request on an input whose enable bit is 0 never raises `irq_o` and never appears on `irq_id_o`.
- R3: Suppose an enabled request is held high and nothing is pending. Then `irq_o` is still 0 after the second rising edge that follows the input change, and it is 1 after the third rising edge (two synchronizer stages plus the capture register).
- R4: When several enabled requests are active, the captured number is the lowest active index. Input 0 has the highest priority and input 7 the lowest. `irq_id_o` gives that index as an unsigned 3-bit binary value.
- R5: While an interrupt is pending and no acknowledge is given, `irq_o` stays 1 and `irq_id_o` keeps its value, even if other requests arrive, including ones of higher priority.
- R6: An acknowledge sampled on a rising edge while pending clears the pending state at that edge. `irq_o` is 0 afterwards, and `irq_id_o` reads 0 whenever nothing is pending.
- R7: Nothing is captured on the edge that takes the acknowledge. If an enabled request is still active, `irq_o` rises again on the following edge.
- R8: Clearing the enable bit of a source whose interrupt is pending does not drop or alter that pending interrupt before it is acknowledged.
- R9: When `mask_we_i` is 1 on a rising edge, the mask is loaded from `mask_wdata_i`. Bit i enables input i, and the new mask applies to captures from the next edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 8 | Level-sensitive request lines, bit i is source i |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | New enable bits, bit i enables source i |
| ack_i | input | 1 | One-cycle acknowledge from the processor |
| irq_o | output | 1 | Interrupt line to the processor |
| irq_id_o | output | 3 | Number of the pending source, 0 when idle |

## Verification
The tests drive inputs on falling edges and sample on falling edges, counting rising edges between them. A request change is due on `irq_o` after exactly three rising edges, so the bench samples after both the second and third edges. An acknowledge takes effect at the single edge that samples it, and a re-capture follows one edge later; the bench checks `irq_o` low at the falling edge right after the acknowledge, then high one edge later. Frozen behaviour is checked by holding new stimulus for at least four edges, which exceeds the synchronizer and capture latency, before reading the outputs again.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared types for the prioritized interrupt controller.
// Assumes a single clock domain for all users of these types.
package irqc_pkg;

    // Pending-state encoding of the capture controller.
    typedef enum logic {
        PST_IDLE = 1'b0,
        PST_HELD = 1'b1
    } pend_state_e;

    // Width of a source number for a given source count.
    function automatic int unsigned id_width(input int unsigned n_src);
        return (n_src > 1) ? $clog2(n_src) : 1;
    endfunction

endpackage : irqc_pkg

// File: rtl/irqc_sync.sv
// Module irqc_sync
// Multi-bit level synchronizer: each bit passes through STAGES flops.
// Assumes every bit is an independent level (no bus coherence needed).
module irqc_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    // First stage samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q[0] <= '0;
        end else begin
            stg_q[0] <= d_i;
        end
    end

    // Remaining stages form the settling chain.
    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_q[s] <= '0;
                end else begin
                    stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];

endmodule : irqc_sync

// File: rtl/irqc_mask_reg.sv
// Module irqc_mask_reg
// Enable register loaded through a write strobe; bit i enables source i.
// Assumes writes come from the same clock domain; resets to all disabled.
module irqc_mask_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] mask_o
);

    logic [WIDTH-1:0] mask_q;

    // Hold the enable bits; load on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (we_i) begin
            mask_q <= wdata_i;
        end
    end

    assign mask_o = mask_q;

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mask_o == $past(wdata_i))); // R9

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mask_o)); // R9

endmodule : irqc_mask_reg

// File: rtl/irqc_prio_enc.sv
// Module irqc_prio_enc
// Fixed-priority encoder: the lowest set index wins and is output in binary.
// Assumes req_i is already synchronized and masked; purely combinational
// apart from the clock used by its checks.
module irqc_prio_enc #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned ID_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WIDTH-1:0] req_i,
    output logic            vld_o,
    output logic [ID_W-1:0] id_o
);

    logic [WIDTH:0]   lower_any;
    logic [WIDTH-1:0] win_oh;

    assign lower_any[0] = 1'b0;

    // Build a chain marking whether any lower index is requesting.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_chain
            assign lower_any[i+1] = lower_any[i] | req_i[i];
            assign win_oh[i]      = req_i[i] & ~lower_any[i];
        end
    endgenerate

    // Turn the one-hot winner into a binary number.
    always_comb begin
        id_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (win_oh[i]) begin
                id_o = id_o | ID_W'(i);
            end
        end
    end

    assign vld_o = lower_any[WIDTH];

    AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> $onehot0(win_oh) && (win_oh != '0)); // R4

    AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (req_i[id_o] &&
                   ((req_i & ((WIDTH'(1) << id_o) - WIDTH'(1))) == '0))); // R4

endmodule : irqc_prio_enc

// File: rtl/irqc_pend_ctrl.sv
// Module irqc_pend_ctrl
// Holds the single outstanding interrupt: captures a winner when idle,
// freezes it until acknowledged, and refuses a capture on the ack edge.
// Assumes ack_i is a one-cycle pulse; an ack while idle is ignored.
module irqc_pend_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grant_vld_i,
    input  logic [ID_W-1:0] grant_id_i,
    input  logic            ack_i,
    output logic            irq_o,
    output logic [ID_W-1:0] irq_id_o
);

    pend_state_e     st_q, st_d;
    logic [ID_W-1:0] id_q, id_d;

    // Decide the next pending state and captured number.
    always_comb begin
        st_d = st_q;
        id_d = id_q;
        unique case (st_q)
            PST_IDLE: begin
                if (grant_vld_i && !ack_i) begin
                    st_d = PST_HELD;
                    id_d = grant_id_i;
                end
            end
            PST_HELD: begin
                if (ack_i) begin
                    st_d = PST_IDLE;
                    id_d = '0;
                end
            end
            default: begin
                st_d = PST_IDLE;
                id_d = '0;
            end
        endcase
    end

    // Register the pending state and captured number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PST_IDLE;
            id_q <= '0;
        end else begin
            st_q <= st_d;
            id_q <= id_d;
        end
    end

    assign irq_o    = (st_q == PST_HELD);
    assign irq_id_o = id_q;

    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> (irq_o && $stable(irq_id_o))); // R5

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !irq_o); // R6 R7

    AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_id_o == '0)); // R6

    AST_CAPTURE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(grant_vld_i) &&
                          (irq_id_o == $past(grant_id_i)))); // R4

endmodule : irqc_pend_ctrl

// File: rtl/prio_irq_ctrl.sv
// Module prio_irq_ctrl
// Top of the prioritized maskable interrupt controller: synchronizes the
// request lines, gates them with the enable mask, picks the lowest index
// and keeps one interrupt outstanding until the processor acknowledges.
// Assumes one clock domain for mask writes and acknowledge; requests may
// be asynchronous levels.
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned ID_W       = id_width(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               mask_we_i,
    input  logic [NUM_SRC-1:0] mask_wdata_i,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [ID_W-1:0]    irq_id_o
);

    logic [NUM_SRC-1:0] req_sync;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] req_en;
    logic               grant_vld;
    logic [ID_W-1:0]    grant_id;
    logic [NUM_SRC-1:0] req_en_prev;

    irqc_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_i),
        .q_o   (req_sync)
    );

    irqc_mask_reg #(
        .WIDTH (NUM_SRC)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask_we_i),
        .wdata_i (mask_wdata_i),
        .mask_o  (mask_q)
    );

    // Only enabled, synchronized requests compete.
    assign req_en = req_sync & mask_q;

    irqc_prio_enc #(
        .WIDTH (NUM_SRC),
        .ID_W  (ID_W)
    ) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_en),
        .vld_o (grant_vld),
        .id_o  (grant_id)
    );

    irqc_pend_ctrl #(
        .ID_W (ID_W)
    ) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_vld_i (grant_vld),
        .grant_id_i  (grant_id),
        .ack_i       (ack_i),
        .irq_o       (irq_o),
        .irq_id_o    (irq_id_o)
    );

    // Keep last cycle's gated requests so the checks can see what was captured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_en_prev <= '0;
        end else begin
            req_en_prev <= req_en;
        end
    end

    AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> req_en_prev[irq_id_o]); // R2

    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && (req_en == '0)) |=> !irq_o); // R2

    AST_IDLE_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !ack_i && (req_en != '0)) |=> irq_o); // R3

endmodule : prio_irq_ctrl

// File: tb/prio_irq_ctrl_tb_top.sv
// Bench for prio_irq_ctrl: directed scenarios, one task each, self-checking.
module prio_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       ack = 1'b0;
    logic       irq;
    logic [2:0] irq_id;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .mask_we_i    (mask_we),
        .mask_wdata_i (mask_wdata),
        .ack_i        (ack),
        .irq_o        (irq),
        .irq_id_o     (irq_id)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_mask(input logic [7:0] m);
        mask_we    = 1'b1;
        mask_wdata = m;
        tick(1);
        mask_we    = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
    endtask

    task automatic settle();
        req = '0;
        tick(3);
        if (irq) pulse_ack();
        tick(1);
    endtask

    // R1 and R2: reset state, nothing enabled.
    task automatic t_reset();
        check("R1 irq after reset", irq, 0);
        check("R1 id after reset", irq_id, 0);
        req = 8'hFF;
        tick(6);
        check("R1 R2 all masked, irq", irq, 0);
        check("R2 all masked, id", irq_id, 0);
        req = '0;
        tick(3);
    endtask

    // R9, R3, R6, R7: single source latency, ack and re-capture.
    task automatic t_latency_ack();
        write_mask(8'h20);
        req = 8'h20;
        tick(2);
        check("R3 irq after two edges", irq, 0);
        tick(1);
        check("R3 R9 irq after three edges", irq, 1);
        check("R4 id of source 5", irq_id, 5);
        pulse_ack();
        check("R6 irq after ack", irq, 0);
        check("R6 id after ack", irq_id, 0);
        tick(1);
        check("R7 re-capture one edge later", irq, 1);
        check("R7 re-capture id", irq_id, 5);
        settle();
    endtask

    // R4: priority under several patterns, all enabled.
    task automatic t_priority();
        logic [7:0] pats [5] = '{8'hA8, 8'h80, 8'hFF, 8'h41, 8'h06};
        int         exps [5] = '{3, 7, 0, 0, 1};
        write_mask(8'hFF);
        for (int k = 0; k < 5; k++) begin
            req = pats[k];
            tick(3);
            check("R4 irq for pattern", irq, 1);
            check("R4 winner id", irq_id, exps[k]);
            settle();
        end
        // R2 with R4: masked higher-priority sources skipped.
        write_mask(8'hF0);
        req = 8'h4F;
        tick(3);
        check("R2 R4 masked low indices skipped", irq_id, 6);
        settle();
    endtask

    // R5: a new higher-priority request does not disturb the pending one.
    task automatic t_single_outstanding();
        write_mask(8'hFF);
        req = 8'h10;
        tick(3);
        check("R5 first capture id", irq_id, 4);
        req = 8'h11;
        tick(4);
        check("R5 irq held", irq, 1);
        check("R5 id frozen", irq_id, 4);
        pulse_ack();
        check("R6 released", irq, 0);
        tick(1);
        check("R7 next winner irq", irq, 1);
        check("R4 R7 next winner id", irq_id, 0);
        settle();
    endtask

    // R8 and R2: mask cleared while pending.
    task automatic t_mask_while_pending();
        write_mask(8'hFF);
        req = 8'h04;
        tick(3);
        check("R8 captured id", irq_id, 2);
        write_mask(8'h00);
        tick(3);
        check("R8 irq kept after mask clear", irq, 1);
        check("R8 id kept after mask clear", irq_id, 2);
        pulse_ack();
        tick(4);
        check("R2 masked source not re-raised", irq, 0);
        settle();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_latency_ack();
        t_priority();
        t_single_outstanding();
        t_mask_while_pending();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule : prio_irq_ctrl_tb_top